// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This peripheral watches over system software. Once it is enabled, software has to restart its countdown at regular intervals. If software stops doing so and the interval runs out, the block can pull a system-reset line for a fixed number of clock cycles. The countdown is kept in half-second units. A prescaler turns the core clock into half-second ticks, and its division ratio is a parameter, so a simulation can run with very short intervals.

Software reaches the block through a small register bus with three registers:

- **Restart register (0x10).** A write here restarts the countdown, but only when the written word carries a strobe bit together with a 12-bit key. Any other write to this register is ignored.
- **Action register (0x14).** Its two low bits select what an expiry does.
- **Setup register (0x18).** It holds the run bit and a 4-bit interval code.

The interval codes are not spaced evenly:

- Code 0 gives half a second.
- Codes 1 to 6 give whole seconds.
- Higher codes step in two-second increments up to sixteen seconds.

Every expiry also sets a sticky flag, which stays set until the next write to the setup register.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, `sys_rst_o` and `timeout_flag_o` are low, and reads of 0x14 and 0x18 return zero.
- R2: A read of 0x14 or 0x18 returns the full 32-bit word last written there. A read of 0x10, or of any unmapped address, returns zero.
- R3: A write to 0x10 reloads the countdown only when bit 0 is 1 and bits 12:1 equal 0xA57. Any other write to 0x10 leaves the running countdown unchanged.
- R4: The interval code is setup bits 7:4. With H = HALF_SEC_CYCLES, the mapping in half-second units is:
  - code 0 gives 1 unit;
  - codes 1 to 6 give 2 units per code;
  - codes 7, 8, 9, 0xA and 0xB give 16, 20, 24, 28 and 32 units;
  - codes 0xC to 0xF give 32 units.
  The expiry takes effect exactly N·H cycles after the write that reloaded the countdown, where N is the number of units.
- R5: Setup bit 0 is the run bit. A setup write that changes the run bit or the interval code reloads the countdown. A setup write with unchanged values does not reload it. Writing zero stops the countdown, and no expiry follows.
- R6: On expiry, `sys_rst_o` rises in the cycle after expiry and stays high for exactly RST_PULSE_CYCLES cycles, but only when action bits 1:0 equal 01. With any other action value, the line stays low.
- R7: Every expiry while running sets `timeout_flag_o`. The flag holds until any write to 0x18 clears it, and that clear wins over an expiry in the same cycle.
- R8: After an expiry the countdown stays expired. No further pulse comes until the countdown is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| sys_rst_o | output | 1 | System-reset pulse |
| timeout_flag_o | output | 1 | Sticky expiry flag |

## Verification
Register readback has no latency: `bus_rdata` follows `bus_addr` within the same cycle, so the bench samples it just after changing the address, in the low clock phase. Timed results are counted from the clock edge that takes the reloading write:

- The pulse appears after edge N·H.
- It ends after edge N·H+RST_PULSE_CYCLES.
- The flag rises on the same edge as the pulse.

Each check therefore samples at the falling edge one cycle before and exactly at those counts. That placement catches an off-by-one in the prescaler, the countdown or the pulse stretcher.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0]  ADDR_RESTART = 8'h10;
  localparam logic [7:0]  ADDR_ACTION  = 8'h14;
  localparam logic [7:0]  ADDR_SETUP   = 8'h18;
  localparam logic [11:0] RESTART_KEY  = 12'hA57;
  localparam logic [1:0]  ACT_SYSRST   = 2'b01;
  localparam int          HALVES_W     = 6;

  typedef logic [HALVES_W-1:0] halves_t;

  // Interval length in half-second units for a 4-bit code.
  function automatic halves_t interval_halves(input logic [3:0] code);
    halves_t n;
    case (code)
      4'h0:                            n = halves_t'(1);
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6: n = halves_t'({code, 1'b0});
      4'h7:                            n = halves_t'(16);
      4'h8:                            n = halves_t'(20);
      4'h9:                            n = halves_t'(24);
      4'hA:                            n = halves_t'(28);
      default:                         n = halves_t'(32);
    endcase
    return n;
  endfunction

  // Strobe bit plus key field make a valid restart word.
  function automatic logic restart_word_ok(input logic [31:0] d);
    return d[0] && (d[12:1] == RESTART_KEY);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        expire,
  output logic [31:0] rdata,
  output logic        kick,
  output logic        setup_change,
  output logic        run,
  output logic [3:0]  code_next,
  output logic [1:0]  action,
  output logic        flag
);

  logic [31:0] action_q, setup_q;
  logic        flag_q;
  logic        setup_wr, action_wr;

  assign setup_wr  = wr && (addr == ADDR_SETUP);
  assign action_wr = wr && (addr == ADDR_ACTION);
  assign kick      = wr && (addr == ADDR_RESTART) && restart_word_ok(wdata);

  assign setup_change = setup_wr &&
                        ((wdata[0] != setup_q[0]) || (wdata[7:4] != setup_q[7:4]));
  assign code_next    = setup_wr ? wdata[7:4] : setup_q[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      action_q <= '0;
      setup_q  <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (action_wr) action_q <= wdata;
      if (setup_wr)  setup_q  <= wdata;
      if (setup_wr)      flag_q <= 1'b0;
      else if (expire)   flag_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      ADDR_ACTION: rdata = action_q;
      ADDR_SETUP:  rdata = setup_q;
      default:     rdata = '0;
    endcase
  end

  assign run    = setup_q[0];
  assign action = action_q[1:0];
  assign flag   = flag_q;

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int HALF_SEC_CYCLES = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);

  localparam int CW = (HALF_SEC_CYCLES > 1) ? $clog2(HALF_SEC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_SEC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear || !run)          cnt_q <= '0;
    else if (cnt_q == LAST)          cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && !clear && (cnt_q == LAST);

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    tick,
  input  logic    reload,
  input  halves_t reload_val,
  output halves_t remain,
  output logic    expire
);

  halves_t remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  remain_q <= '0;
    else if (reload)                             remain_q <= reload_val;
    else if (run && tick && (remain_q != '0))    remain_q <= remain_q - 1'b1;
  end

  assign expire = run && tick && !reload && (remain_q == halves_t'(1));
  assign remain = remain_q;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int RST_PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);

  localparam int PW = $clog2(RST_PULSE_CYCLES + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= PW'(RST_PULSE_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int HALF_SEC_CYCLES  = 12_000_000,
  parameter int RST_PULSE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sys_rst_o,
  output logic        timeout_flag_o
);

  // Named internal events, brought out for the checker.
  logic       kick_evt;
  logic       setup_change_evt;
  logic       reload_evt;
  logic       expire_evt;
  logic       half_tick;
  logic       run_en;
  logic       fire_evt;
  logic [3:0] code_next;
  logic [1:0] action_sel;
  halves_t    reload_halves;
  halves_t    remain_halves;

  wdog_regs regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (bus_wr),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .expire       (expire_evt),
    .rdata        (bus_rdata),
    .kick         (kick_evt),
    .setup_change (setup_change_evt),
    .run          (run_en),
    .code_next    (code_next),
    .action       (action_sel),
    .flag         (timeout_flag_o)
  );

  assign reload_evt    = kick_evt || setup_change_evt;
  assign reload_halves = interval_halves(code_next);

  wdog_prescaler #(.HALF_SEC_CYCLES(HALF_SEC_CYCLES)) pre_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_en),
    .clear (reload_evt),
    .tick  (half_tick)
  );

  wdog_downcount cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_en),
    .tick       (half_tick),
    .reload     (reload_evt),
    .reload_val (reload_halves),
    .remain     (remain_halves),
    .expire     (expire_evt)
  );

  assign fire_evt = expire_evt && (action_sel == ACT_SYSRST);

  wdog_pulse #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) pulse_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire_evt),
    .active (sys_rst_o)
  );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int RST_PULSE_CYCLES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        sys_rst_o,
  input logic        timeout_flag_o,
  input logic        kick_evt,
  input logic        reload_evt,
  input logic        expire_evt,
  input logic        run_en,
  input logic [1:0]  action_sel,
  input halves_t     reload_halves,
  input halves_t     remain_halves
);

  int unsigned hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= 0;
    else if (sys_rst_o) hi_len <= hi_len + 1;
    else                hi_len <= 0;
  end

  assert_restart_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_RESTART) |-> (bus_rdata == 32'h0));

  assert_kick_reloads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |=> (remain_halves == $past(reload_halves)));

  assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reload_evt) |=> $stable(remain_halves));

  assert_pulse_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && action_sel == ACT_SYSRST) |=> sys_rst_o);

  assert_pulse_needs_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> ($past(action_sel) == ACT_SYSRST));

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (hi_len < RST_PULSE_CYCLES));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_SETUP) |=> !timeout_flag_o);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !(bus_wr && bus_addr == ADDR_SETUP)) |=> timeout_flag_o);

endmodule

bind wdog_keyed wdog_keyed_chk #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_rdata      (bus_rdata),
  .sys_rst_o      (sys_rst_o),
  .timeout_flag_o (timeout_flag_o),
  .kick_evt       (kick_evt),
  .reload_evt     (reload_evt),
  .expire_evt     (expire_evt),
  .run_en         (run_en),
  .action_sel     (action_sel),
  .reload_halves  (reload_halves),
  .remain_halves  (remain_halves)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;

  localparam int H = 4;
  localparam int P = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        sys_rst_o;
  logic        timeout_flag_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  wdog_keyed #(.HALF_SEC_CYCLES(H), .RST_PULSE_CYCLES(P)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .sys_rst_o      (sys_rst_o),
    .timeout_flag_o (timeout_flag_o)
  );

  // Bench view of the interval table: seconds scaled to half units.
  function automatic int exp_units(input int code);
    int secs2;
    if (code == 0)       secs2 = 1;
    else if (code <= 6)  secs2 = code * 2;
    else if (code <= 11) secs2 = (8 + (code - 7) * 2) * 2;
    else                 secs2 = 32;
    return secs2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Called at a falling edge; the write is taken at the next rising edge.
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // R4 / R6 / R7 / R8: full expiry timing for one code and action.
  task automatic run_expiry(input int code, input logic [1:0] act);
    int n;
    n = exp_units(code) * H;
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h14, {30'h0, act});
    wr_reg(8'h18, {24'h0, code[3:0], 4'h1});
    step(n - 1);
    check("R4 before expiry", {31'h0, sys_rst_o}, 32'h0);
    check("R7 flag before expiry", {31'h0, timeout_flag_o}, 32'h0);
    step(1);
    check("R4 expiry edge", {31'h0, sys_rst_o}, {31'h0, act == 2'b01});
    check("R7 flag set", {31'h0, timeout_flag_o}, 32'h1);
    if (act == 2'b01) begin
      step(P - 1);
      check("R6 pulse still high", {31'h0, sys_rst_o}, 32'h1);
      step(1);
      check("R6 pulse ended", {31'h0, sys_rst_o}, 32'h0);
    end
    step(n + 2);
    check("R8 no second pulse", {31'h0, sys_rst_o}, 32'h0);
    check("R7 flag sticky", {31'h0, timeout_flag_o}, 32'h1);
    wr_reg(8'h18, 32'h0);
    check("R7 flag cleared by setup write", {31'h0, timeout_flag_o}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, sh_act, sh_setup;
    int seed;
    seed = $urandom(32'd2024);
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check("R1 rst low", {31'h0, sys_rst_o}, 32'h0);
    check("R1 flag low", {31'h0, timeout_flag_o}, 32'h0);
    rd_reg(8'h14, d); check("R1 action zero", d, 32'h0);
    rd_reg(8'h18, d); check("R1 setup zero", d, 32'h0);

    // R2 random register traffic with a shadow model
    sh_act = 0; sh_setup = 0;
    for (int i = 0; i < 40; i++) begin
      int sel;
      logic [31:0] v;
      sel = $urandom_range(0, 3);
      v = $urandom;
      if (sel == 0)      begin wr_reg(8'h14, v); sh_act = v; end
      else if (sel == 1) begin v[0] = 1'b0; wr_reg(8'h18, v); sh_setup = v; end
      else if (sel == 2) wr_reg(8'h10, v);
      else               wr_reg(8'h20 + 8'($urandom_range(0, 15)), v);
      rd_reg(8'h14, d); check("R2 action readback", d, sh_act);
      rd_reg(8'h18, d); check("R2 setup readback", d, sh_setup);
      rd_reg(8'h10, d); check("R2 restart reads zero", d, 32'h0);
      rd_reg(8'h3C, d); check("R2 unmapped reads zero", d, 32'h0);
    end

    // R4 every code, R6 with reset action
    for (int c = 0; c < 16; c++) run_expiry(c, 2'b01);
    // R6 other action values: flag only
    run_expiry(3, 2'b10);
    run_expiry(0, 2'b00);
    run_expiry(1, 2'b11);

    // R3 valid restart reloads
    wr_reg(8'h14, 32'h1);
    wr_reg(8'h18, 32'h11);              // code 1 -> 8 cycles
    step(4);
    wr_reg(8'h10, {19'h0, 12'hA57, 1'b1});
    step(7);
    check("R3 kick delays expiry", {31'h0, sys_rst_o}, 32'h0);
    step(1);
    check("R3 expiry after kick", {31'h0, sys_rst_o}, 32'h1);
    step(P + 2);

    // R3 bad key and missing strobe are ignored
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h18, 32'h11);
    step(2);
    wr_reg(8'h10, {19'h0, 12'hA56, 1'b1});
    wr_reg(8'h10, {19'h0, 12'hA57, 1'b0});
    step(3);
    check("R3 ignored writes, not yet", {31'h0, sys_rst_o}, 32'h0);
    step(1);
    check("R3 ignored writes, original expiry", {31'h0, sys_rst_o}, 32'h1);
    step(P + 2);

    // R5 code change reloads
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h18, 32'h21);              // code 2 -> 16 cycles
    step(5);
    wr_reg(8'h18, 32'h11);              // code 1 -> 8 cycles from here
    step(7);
    check("R5 code change reload, before", {31'h0, sys_rst_o}, 32'h0);
    step(1);
    check("R5 code change reload, expiry", {31'h0, sys_rst_o}, 32'h1);
    step(P + 2);

    // R5 unchanged setup write does not reload
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h18, 32'h11);
    step(3);
    wr_reg(8'h18, 32'h11);
    step(3);
    check("R5 same write no reload, before", {31'h0, sys_rst_o}, 32'h0);
    step(1);
    check("R5 same write no reload, expiry", {31'h0, sys_rst_o}, 32'h1);
    step(P + 2);

    // R5 writing zero stops
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h18, 32'h01);              // code 0 -> 4 cycles
    step(1);
    wr_reg(8'h18, 32'h0);
    step(20);
    check("R5 stopped no reset", {31'h0, sys_rst_o}, 32'h0);
    check("R5 stopped no flag", {31'h0, timeout_flag_o}, 32'h0);

    finish_run();
  end

endmodule